// File: doc/BRIEF.md
# Wide-Word Pixel Histogram Engine

The engine counts how often each pixel value occurs in an image that arrives as a stream of wide words. Each word holds `LANES` pixels of `PIX_W` bits. With the defaults, a 512-bit word carries 64 pixels of 8 bits. Each pixel position (byte lane) feeds its own counting thread, and each thread owns a private table with one counter per pixel value. A thread takes two pixels per update iteration and spends two cycles on each iteration, so it still absorbs one pixel per clock. When both pixels of one iteration fall in the same bin, that bin is raised by two in a single write.

A `start` pulse zeroes every table and opens the input stream. The producer then sends words with a valid/ready handshake and flags the final word with `in_last`. The engine then finishes any pending lone pixels and sums bin k over all threads for every k. It keeps the totals in a result table and raises `done`. The totals are read back by bin index. The run time depends only on the number of words, never on pixel values.

Top module: `hist_engine`

## Requirements
- R1: A `start` pulse clears every bin of every thread, so a new run never includes counts from an earlier run. `in_ready` stays low during the clear sweep.
- R2: The pixel of lane k is bits `[k*PIX_W +: PIX_W]` of `in_data`. After `done`, the total for bin v equals the number of accepted pixels, over all lanes and words, whose value is v.
- R3: Each thread spends exactly two cycles on every update iteration, and an iteration covers up to two pixels.
- R4: Two pixels of one iteration that share a bin add two to that bin. Nothing is lost, whatever the value pattern.
- R5: While in the streaming phase, `in_ready` is high every cycle. A producer that holds `in_valid` high has one word taken per clock.
- R6: A word is counted only on a cycle where both `in_valid` and `in_ready` are high. Words offered while `in_ready` is low, or gaps in `in_valid`, neither drop nor repeat a pixel.
- R7: When a lane ends a run holding a single unpaired pixel, for example after an odd number of words, that pixel is still counted.
- R8: `done` is low after reset and after `start`. It rises once the reduction has summed all bins, and it stays high until the next `start`.
- R9: `rd_count` gives the total of bin `rd_idx` one clock after `rd_idx` is applied.
- R10: The number of cycles from `start` to `done` depends only on the number of words, not on their pixel values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: clear all tables and begin a new image |
| in_valid | input | 1 | Producer has a word on `in_data` |
| in_ready | output | 1 | Engine takes the word this cycle if `in_valid` is high |
| in_data | input | LANES*PIX_W | One word of LANES pixels, lane k in bits `[k*PIX_W +: PIX_W]` |
| in_last | input | 1 | Marks the final word of the image |
| done | output | 1 | Result table complete |
| rd_idx | input | PIX_W | Bin index to read |
| rd_count | output | CNT_W+clog2(LANES) | Total for `rd_idx`, one cycle later |

## Verification
The bench builds the engine with 4 lanes, 4-bit pixels and 16-bit thread counters, which gives 16 bins. With so few bins, same-bin pairs inside one iteration happen all the time. The clear and reduction sweeps stay short, and every bin of every run can be read back and compared. The stream patterns include a constant value, a value fixed per lane, distinct ramps and scrambled values. Some runs use odd word counts to leave lone pixels, and some insert gaps in `in_valid`. Two runs of equal length but different content are timed from `start` to `done` to show that the timing does not depend on content.

// File: rtl/hist_pkg.sv
package hist_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLEAR,
    ST_RUN,
    ST_DRAIN,
    ST_REDUCE,
    ST_SETTLE,
    ST_DONE
  } hist_state_t;

endpackage

// File: rtl/hist_lane.sv
module hist_lane #(
  parameter int PIX_W = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_en,
  input  logic [PIX_W-1:0] clr_addr,
  input  logic             px_valid,
  input  logic [PIX_W-1:0] px_data,
  output logic             px_ready,
  input  logic             flush,
  output logic             idle,
  input  logic             rd_en,
  input  logic [PIX_W-1:0] rd_addr,
  output logic [CNT_W-1:0] rd_cnt
);

  localparam int BINS = 1 << PIX_W;

  logic [CNT_W-1:0] bin_mem [BINS];

  // pair collector
  logic [PIX_W-1:0] col0, col1;
  logic [1:0]       col_cnt;
  // update engine
  logic             phase_wr;
  logic [PIX_W-1:0] wk_a, wk_b;
  logic             wk_bv;
  logic             take, acc, same;

  // memory ports
  logic [PIX_W-1:0] adra, adrb;
  logic             wea, web;
  logic [CNT_W-1:0] dina, dinb, qa, qb;

  assign take     = !phase_wr && !clr_en &&
                    ((col_cnt == 2'd2) || (flush && col_cnt == 2'd1));
  assign px_ready = !clr_en && ((col_cnt != 2'd2) || take);
  assign acc      = px_valid && px_ready;
  assign same     = wk_bv && (wk_a == wk_b);
  assign idle     = (col_cnt == 2'd0) && !phase_wr;
  assign rd_cnt   = qa;

  always_comb begin
    wea  = 1'b0;
    dina = '0;
    if (clr_en) begin
      adra = clr_addr;
      wea  = 1'b1;
    end else if (phase_wr) begin
      adra = wk_a;
      wea  = 1'b1;
      dina = qa + (same ? CNT_W'(2) : CNT_W'(1));
    end else if (rd_en) begin
      adra = rd_addr;
    end else begin
      adra = col0;
    end
  end

  always_comb begin
    adrb = phase_wr ? wk_b : col1;
    web  = phase_wr && wk_bv && !same && !clr_en;
    dinb = qb + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (wea) bin_mem[adra] <= dina;
    if (web) bin_mem[adrb] <= dinb;
    qa <= bin_mem[adra];
    qb <= bin_mem[adrb];
  end

  always_ff @(posedge clk) begin
    if (rst || clr_en) begin
      col_cnt  <= 2'd0;
      phase_wr <= 1'b0;
      wk_bv    <= 1'b0;
    end else begin
      if (take) begin
        wk_a     <= col0;
        wk_b     <= col1;
        wk_bv    <= (col_cnt == 2'd2);
        phase_wr <= 1'b1;
        if (acc) begin
          col0    <= px_data;
          col_cnt <= 2'd1;
        end else begin
          col_cnt <= 2'd0;
        end
      end else begin
        if (phase_wr) phase_wr <= 1'b0;
        if (acc) begin
          if (col_cnt == 2'd0) col0 <= px_data;
          else                 col1 <= px_data;
          col_cnt <= col_cnt + 2'd1;
        end
      end
    end
  end

  AST_ITER_TWO_CYCLES: assert property (@(posedge clk) disable iff (rst)
    phase_wr |=> !phase_wr); // R3

  AST_SWEEP_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> idle); // R7

endmodule

// File: rtl/hist_reduce.sv
module hist_reduce #(
  parameter int LANES = 64,
  parameter int PIX_W = 8,
  parameter int CNT_W = 32,
  parameter int SUM_W = CNT_W + $clog2(LANES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES*CNT_W-1:0] lane_cnt,
  input  logic                   wr_en,
  input  logic [PIX_W-1:0]       wr_idx,
  input  logic [PIX_W-1:0]       rd_idx,
  output logic [SUM_W-1:0]       rd_count
);

  localparam int BINS = 1 << PIX_W;

  logic [SUM_W-1:0] res_mem [BINS];
  logic [SUM_W-1:0] total;

  always_comb begin
    total = '0;
    for (int i = 0; i < LANES; i++)
      total = total + SUM_W'(lane_cnt[i*CNT_W +: CNT_W]);
  end

  always_ff @(posedge clk) begin
    if (wr_en) res_mem[wr_idx] <= total;
    rd_count <= res_mem[rd_idx];
  end

  AST_SWEEP_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
    (wr_en && $past(wr_en)) |-> (wr_idx == $past(wr_idx) + PIX_W'(1))); // R2

endmodule

// File: rtl/hist_engine.sv
module hist_engine
  import hist_pkg::*;
#(
  parameter int LANES = 64,
  parameter int PIX_W = 8,
  parameter int CNT_W = 32,
  parameter int SUM_W = CNT_W + $clog2(LANES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [LANES*PIX_W-1:0] in_data,
  input  logic                   in_last,
  output logic                   done,
  input  logic [PIX_W-1:0]       rd_idx,
  output logic [SUM_W-1:0]       rd_count
);

  localparam logic [PIX_W-1:0] LAST_BIN = {PIX_W{1'b1}};

  hist_state_t      state;
  logic [PIX_W-1:0] addr;
  logic             red_v;
  logic [PIX_W-1:0] red_idx;

  logic [LANES-1:0]       lane_rdy, lane_idle;
  logic [LANES*CNT_W-1:0] lane_cnt;
  logic                   run, clr_en, flush, rd_en, beat;

  assign run      = (state == ST_RUN);
  assign clr_en   = (state == ST_CLEAR);
  assign flush    = (state == ST_DRAIN);
  assign rd_en    = (state == ST_REDUCE);
  assign in_ready = run && (&lane_rdy);
  assign beat     = in_valid && in_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    hist_lane #(.PIX_W(PIX_W), .CNT_W(CNT_W)) i_lane (
      .clk      (clk),
      .rst      (rst),
      .clr_en   (clr_en),
      .clr_addr (addr),
      .px_valid (beat),
      .px_data  (in_data[g*PIX_W +: PIX_W]),
      .px_ready (lane_rdy[g]),
      .flush    (flush),
      .idle     (lane_idle[g]),
      .rd_en    (rd_en),
      .rd_addr  (addr),
      .rd_cnt   (lane_cnt[g*CNT_W +: CNT_W])
    );
  end

  hist_reduce #(.LANES(LANES), .PIX_W(PIX_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) i_reduce (
    .clk      (clk),
    .rst      (rst),
    .lane_cnt (lane_cnt),
    .wr_en    (red_v),
    .wr_idx   (red_idx),
    .rd_idx   (rd_idx),
    .rd_count (rd_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      addr    <= '0;
      red_v   <= 1'b0;
      red_idx <= '0;
      done    <= 1'b0;
    end else begin
      red_v   <= rd_en;
      red_idx <= addr;
      if (start) begin
        state <= ST_CLEAR;
        addr  <= '0;
        done  <= 1'b0;
      end else begin
        unique case (state)
          ST_CLEAR: begin
            addr <= addr + PIX_W'(1);
            if (addr == LAST_BIN) state <= ST_RUN;
          end
          ST_RUN:    if (beat && in_last) state <= ST_DRAIN;
          ST_DRAIN: begin
            if (&lane_idle) begin
              state <= ST_REDUCE;
              addr  <= '0;
            end
          end
          ST_REDUCE: begin
            addr <= addr + PIX_W'(1);
            if (addr == LAST_BIN) state <= ST_SETTLE;
          end
          ST_SETTLE: begin
            state <= ST_DONE;
            done  <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_STREAM_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
    run |-> in_ready); // R5

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done); // R8

  AST_CLEAR_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (rst)
    clr_en |-> !(|lane_rdy)); // R1

endmodule

// File: tb/test_hist_engine.sv
`timescale 1ns/1ps
module test_hist_engine;

  localparam int LANES = 4;
  localparam int PIX_W = 4;
  localparam int CNT_W = 16;
  localparam int SUM_W = CNT_W + $clog2(LANES);
  localparam int BINS  = 1 << PIX_W;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic                   start = 1'b0;
  logic                   in_valid = 1'b0;
  logic                   in_ready;
  logic [LANES*PIX_W-1:0] in_data = '0;
  logic                   in_last = 1'b0;
  logic                   done;
  logic [PIX_W-1:0]       rd_idx = '0;
  logic [SUM_W-1:0]       rd_count;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int exp_h [BINS];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hist_engine #(.LANES(LANES), .PIX_W(PIX_W), .CNT_W(CNT_W)) i_hist_engine (
    .clk(clk), .rst(rst), .start(start), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .done(done), .rd_idx(rd_idx), .rd_count(rd_count)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int pix(input int mode, input int b, input int l);
    case (mode)
      0: return 5;
      1: return (b * LANES + l) % BINS;
      2: return ((b * 7 + l * 3 + b * l) ^ (b >> 1)) % BINS;
      default: return l % BINS;
    endcase
  endfunction

  task automatic run_image(input int mode, input int beats, input int gap,
                           input string req, output int lat);
    int t0, first_acc, last_acc, waited;
    bit rdy;
    for (int v = 0; v < BINS; v++) exp_h[v] = 0;
    @(negedge clk); start = 1'b1;
    t0 = cyc;
    @(negedge clk); start = 1'b0;
    first_acc = -1; last_acc = -1;
    for (int b = 0; b < beats; b++) begin
      if (gap > 0 && (b % 3) == 1) begin
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
      end
      for (int l = 0; l < LANES; l++) begin
        in_data[l*PIX_W +: PIX_W] = PIX_W'(pix(mode, b, l));
        exp_h[pix(mode, b, l)]++;
      end
      in_valid = 1'b1;
      in_last  = (b == beats - 1);
      rdy = 1'b0;
      while (!rdy) begin
        rdy = in_ready;
        @(posedge clk);
        if (rdy) begin
          if (first_acc < 0) first_acc = cyc;
          last_acc = cyc;
        end
        @(negedge clk);
      end
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
    in_data  = '1;
    waited = 0;
    while (!done && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    lat = cyc - t0;
    check(done, "R8", "done after reduction", int'(done), 1);
    if (gap == 0)
      check(last_acc - first_acc == beats - 1, "R3 R5", "consecutive intake span",
            last_acc - first_acc, beats - 1);
    for (int v = 0; v < BINS; v++) begin
      rd_idx = PIX_W'(v);
      @(negedge clk);
      check(int'(rd_count) == exp_h[v], req, $sformatf("bin %0d total", v),
            int'(rd_count), exp_h[v]);
    end
  endtask

  task automatic t_reset();
    check(done == 1'b0, "R8", "done after reset", int'(done), 0);
    check(in_ready == 1'b0, "R6", "ready after reset", int'(in_ready), 0);
  endtask

  task automatic t_clear_blocks();
    int lat;
    // word offered right after start waits out the clear sweep (R1, R6)
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(in_ready == 1'b0, "R1", "ready during clear", int'(in_ready), 0);
    check(done == 1'b0, "R8", "done after start", int'(done), 0);
    run_image(2, 11, 2, "R6", lat);
  endtask

  task automatic t_latency();
    int la, lb;
    run_image(0, 12, 0, "R4", la);
    run_image(2, 12, 0, "R2", lb);
    check(la == lb, "R10", "start-to-done cycles by content", la, lb);
  endtask

  task automatic t_done_hold();
    repeat (10) @(negedge clk);
    check(done == 1'b1, "R8", "done held while idle", int'(done), 1);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done == 1'b0, "R8", "done dropped by start", int'(done), 0);
  endtask

  task automatic t_readout_latency();
    int lat;
    run_image(1, 4, 0, "R2", lat);
    rd_idx = PIX_W'(0);
    @(negedge clk);
    rd_idx = PIX_W'(BINS - 1);
    check(int'(rd_count) == exp_h[0], "R9", "old index still shown", int'(rd_count), exp_h[0]);
    @(negedge clk);
    check(int'(rd_count) == exp_h[BINS-1], "R9", "new index after one clock",
          int'(rd_count), exp_h[BINS-1]);
  endtask

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_image(1, 20, 0, "R2", lat);
    run_image(0, 16, 0, "R4", lat);
    run_image(3, 9, 0, "R7", lat);
    run_image(1, 7, 0, "R1", lat);
    run_image(2, 25, 2, "R6", lat);
    t_clear_blocks();
    t_latency();
    t_done_hold();
    t_readout_latency();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule